// File: doc/BRIEF.md
# Palette DAC Host Register Port

This block is the processor-facing control port of a palette-based video DAC. A two-bit space select, an access strobe and a write flag steer each bus cycle to one of four places. The places are an 8-bit index pointer, a small bank of 8-bit control registers reached indirectly through that pointer, a 256-entry colour table with 10 bits per colour, and a mode register that has its own select code. Every location can be read back, so software can verify a value right after writing it, or after the whole setup is done.

Colour table traffic moves in groups of three: red, then green, then blue, all for the entry the pointer names. The pointer steps on after the blue access. Two bits of the mode register do not act on their level. Each one watches the last three values written to it and emits a one-cycle strobe when they match a fixed pattern. One strobe resets the pixel pipelines; the other requests a load-timing calibration. A control bit can also raise the calibration request on every rising edge of vertical sync.

The bus is a plain strobe interface with no back-pressure. An access is taken in the cycle `acc_en` is high. Read data comes back one clock later, flagged by `rd_valid`.

Top module: `palette_host_port`

## Requirements
- R1: After reset the pointer, pixel mask, the three control registers and the mode register are 00h. `rdata`, `rd_valid`, `resync_pulse` and `calib_pulse` are 0, and the colour phase is red.
- R2: With `sel`=00, a write loads `wdata[7:0]` into the pointer, and a read returns the pointer.
- R3: With `sel`=10, the access goes to the register the pointer selects: 04h is the pixel mask, 05h control 1, 06h control 2, 07h control 3. At any other pointer value a write changes nothing and a read returns 000h.
- R4: With `sel`=01, three writes supply red, green and blue. The blue write stores all three 10-bit values into the entry at the pointer.
- R5: A colour read at the red phase captures the whole entry. The green and blue reads that follow return that captured copy.
- R6: After the blue access of a group, whether read or write, the pointer adds one and wraps from FFh to 00h.
- R7: Any pointer write returns the colour phase to red.
- R8: With `sel`=11, a write loads the mode register from `wdata[7:0]`, and a read returns it.
- R9: When bit 0 of three consecutive mode-register writes is 1, 0, 1, `resync_pulse` is high for exactly the one cycle after the third write. Accesses to other places between those writes neither break nor advance the sequence.
- R10: When bit 5 of three consecutive mode-register writes is 0, 1, 0, `calib_pulse` is high for the one cycle after the third write.
- R11: While bit 0 of control 1 is 1, a rising edge of `vsync` gives a one-cycle `calib_pulse` in the cycle after the edge is sampled. While that bit is 0, the edge gives no pulse.
- R12: A read returns its data in `rdata` one cycle after the strobe, with `rd_valid` high for that cycle. Reads of 8-bit places return 0 in `rdata[9:8]`, and writes to them use `wdata[7:0]` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per high cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| sel | input | 2 | Space select: 00 pointer, 01 colour table, 10 indexed registers, 11 mode |
| wdata | input | 10 | Write data |
| vsync | input | 1 | Vertical sync level |
| rdata | output | 10 | Read data, one cycle after the read strobe |
| rd_valid | output | 1 | Marks the cycle `rdata` carries read data |
| pixel_mask | output | 8 | Pixel mask register |
| ctrl1 | output | 8 | Control register 1 |
| ctrl2 | output | 8 | Control register 2 |
| ctrl3 | output | 8 | Control register 3 |
| resync_pulse | output | 1 | One-cycle pipeline resynchronisation strobe |
| calib_pulse | output | 1 | One-cycle load-timing calibration strobe |

## Verification
The register space is tried in two orders. The first reads each location back right after writing it. The second writes several registers and then reads them all, which shows that the pointer decoding keeps each location separate. Colour groups are written and read at a middle entry and at entry FFh. A group is also broken off by a pointer write, to show the phase reset and the wrap. The mode bits are given the matching patterns, a non-matching run of equal values, and a matching run with unrelated accesses in between. The vertical-sync trigger is applied with its enable set and with it clear.

// File: rtl/palreg_pkg.sv
package palreg_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'b00,
    SEL_PAL  = 2'b01,
    SEL_REG  = 2'b10,
    SEL_MODE = 2'b11
  } space_sel_e;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } colour_ph_e;
endpackage

// File: rtl/host_ctrl_regs.sv
module host_ctrl_regs
  import palreg_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CW       = 8,
  parameter int REG_BASE = 4,
  parameter int NUM_CTRL = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_en,
  input  logic                   acc_wr,
  input  logic [1:0]             sel,
  input  logic [CW-1:0]          wbyte,
  input  logic                   ptr_inc,
  output logic [AW-1:0]          ptr,
  output logic                   ptr_wr,
  output logic                   mode_wr,
  output logic [CW-1:0]          mode_q,
  output logic [NUM_CTRL*CW-1:0] ctrl_flat,
  output logic [CW-1:0]          reg_rd
);
  logic [CW-1:0] ctrl_q [NUM_CTRL];
  logic          reg_wr;

  assign ptr_wr  = acc_en && acc_wr && (sel == SEL_PTR);
  assign mode_wr = acc_en && acc_wr && (sel == SEL_MODE);
  assign reg_wr  = acc_en && acc_wr && (sel == SEL_REG);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (ptr_wr)  ptr <= wbyte[AW-1:0];
    else if (ptr_inc) ptr <= AW'(ptr + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= wbyte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTRL; i++) ctrl_q[i] <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (ptr == AW'(REG_BASE + i)) ctrl_q[i] <= wbyte;
    end
  end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_flat
    assign ctrl_flat[g*CW +: CW] = ctrl_q[g];
  end

  always_comb begin
    reg_rd = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (ptr == AW'(REG_BASE + i)) reg_rd = ctrl_q[i];
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc && !ptr_wr |=> ptr == AW'($past(ptr) + 1'b1)); // R6
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr == $past(wbyte[AW-1:0])); // R2
endmodule

// File: rtl/colour_table.sv
module colour_table
  import palreg_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pal_en,
  input  logic          acc_wr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ptr,
  input  logic          ptr_wr,
  output logic          ptr_inc,
  output logic [DW-1:0] pal_rd
);
  localparam int ENTRIES = 1 << AW;
  localparam int EW      = 3 * DW;

  logic [EW-1:0] table_q [ENTRIES];
  logic [EW-1:0] snap_q;
  logic [DW-1:0] stage_r, stage_g;
  colour_ph_e    phase;
  logic [EW-1:0] cur_entry;

  assign cur_entry = table_q[ptr];
  assign ptr_inc   = pal_en && (phase == PH_BLUE);

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= PH_RED;
    else if (ptr_wr) phase <= PH_RED;
    else if (pal_en) begin
      case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default:  phase <= PH_RED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_r <= '0;
      stage_g <= '0;
      snap_q  <= '0;
    end else if (pal_en) begin
      if (acc_wr) begin
        if (phase == PH_RED)   stage_r <= wdata;
        if (phase == PH_GREEN) stage_g <= wdata;
      end else if (phase == PH_RED) begin
        snap_q <= cur_entry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pal_en && acc_wr && phase == PH_BLUE)
      table_q[ptr] <= {stage_r, stage_g, wdata};
  end

  always_comb begin
    case (phase)
      PH_RED:   pal_rd = cur_entry[EW-1 -: DW];
      PH_GREEN: pal_rd = snap_q[2*DW-1 -: DW];
      default:  pal_rd = snap_q[DW-1:0];
    endcase
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R4
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> phase == PH_RED); // R7
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_RED |=> $stable(snap_q)); // R5
endmodule

// File: rtl/mode_seq.sv
module mode_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr,
  input  logic bit_rs,
  input  logic bit_cal,
  input  logic vsync,
  input  logic vs_cal_en,
  output logic resync_pulse,
  output logic calib_pulse
);
  logic [1:0] hist_rs, hist_cal;
  logic [1:0] seen;
  logic       vs_q;
  logic       hit_rs, hit_cal, vs_rise;

  assign hit_rs  = mode_wr && seen == 2'd2 && hist_rs  == 2'b10 &&  bit_rs;
  assign hit_cal = mode_wr && seen == 2'd2 && hist_cal == 2'b01 && !bit_cal;
  assign vs_rise = vsync && !vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_rs      <= '0;
      hist_cal     <= '0;
      seen         <= '0;
      vs_q         <= 1'b0;
      resync_pulse <= 1'b0;
      calib_pulse  <= 1'b0;
    end else begin
      vs_q         <= vsync;
      resync_pulse <= hit_rs;
      calib_pulse  <= hit_cal || (vs_cal_en && vs_rise);
      if (mode_wr) begin
        hist_rs  <= {hist_rs[0], bit_rs};
        hist_cal <= {hist_cal[0], bit_cal};
        if (seen != 2'd2) seen <= seen + 2'd1;
      end
    end
  end

  AST_RESYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !resync_pulse); // R9
  AST_RESYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |-> $past(mode_wr)); // R9
  AST_CAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    calib_pulse |-> $past(mode_wr) || $past(vsync)); // R10
endmodule

// File: rtl/palette_host_port.sv
module palette_host_port
  import palreg_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          vsync,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic [CW-1:0] pixel_mask,
  output logic [CW-1:0] ctrl1,
  output logic [CW-1:0] ctrl2,
  output logic [CW-1:0] ctrl3,
  output logic          resync_pulse,
  output logic          calib_pulse
);
  localparam int NUM_CTRL = 4;
  localparam int REG_BASE = 4;
  localparam int RS_BIT   = 0;
  localparam int CAL_BIT  = 5;

  logic [AW-1:0]          ptr;
  logic                   ptr_wr, ptr_inc, mode_wr, pal_en, rd_stb;
  logic [CW-1:0]          mode_q, reg_rd;
  logic [NUM_CTRL*CW-1:0] ctrl_flat;
  logic [DW-1:0]          pal_rd;

  assign pal_en = acc_en && (sel == SEL_PAL);
  assign rd_stb = acc_en && !acc_wr;

  host_ctrl_regs #(.AW(AW), .CW(CW), .REG_BASE(REG_BASE), .NUM_CTRL(NUM_CTRL)) regs_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .sel(sel),
    .wbyte(wdata[CW-1:0]), .ptr_inc(ptr_inc), .ptr(ptr), .ptr_wr(ptr_wr),
    .mode_wr(mode_wr), .mode_q(mode_q), .ctrl_flat(ctrl_flat), .reg_rd(reg_rd)
  );

  colour_table #(.AW(AW), .DW(DW)) table_i (
    .clk(clk), .rst_n(rst_n), .pal_en(pal_en), .acc_wr(acc_wr), .wdata(wdata),
    .ptr(ptr), .ptr_wr(ptr_wr), .ptr_inc(ptr_inc), .pal_rd(pal_rd)
  );

  mode_seq seq_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr),
    .bit_rs(wdata[RS_BIT]), .bit_cal(wdata[CAL_BIT]),
    .vsync(vsync), .vs_cal_en(ctrl_flat[CW]),
    .resync_pulse(resync_pulse), .calib_pulse(calib_pulse)
  );

  assign pixel_mask = ctrl_flat[0*CW +: CW];
  assign ctrl1      = ctrl_flat[1*CW +: CW];
  assign ctrl2      = ctrl_flat[2*CW +: CW];
  assign ctrl3      = ctrl_flat[3*CW +: CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        case (sel)
          SEL_PTR:  rdata <= DW'(ptr);
          SEL_PAL:  rdata <= pal_rd;
          SEL_REG:  rdata <= DW'(reg_rd);
          default:  rdata <= DW'(mode_q);
        endcase
      end
    end
  end

  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(sel) != SEL_PAL |-> rdata[DW-1:CW] == '0); // R12
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_wr) |-> $stable(mode_q)); // R8
endmodule

// File: tb/palette_host_port_tb_top.sv
module palette_host_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0, acc_wr = 1'b0, vsync = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;
  logic       rd_valid, resync_pulse, calib_pulse;
  logic [7:0] pixel_mask, ctrl1, ctrl2, ctrl3;
  int checks = 0, errors = 0;
  logic [9:0] got_rd;
  logic       got_v, got_rs, got_cal;

  always #5 clk = ~clk;

  palette_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .sel(sel),
    .wdata(wdata), .vsync(vsync), .rdata(rdata), .rd_valid(rd_valid),
    .pixel_mask(pixel_mask), .ctrl1(ctrl1), .ctrl2(ctrl2), .ctrl3(ctrl3),
    .resync_pulse(resync_pulse), .calib_pulse(calib_pulse)
  );

  // {write, sel, data-or-expected}; tags name the requirement each read checks
  localparam int NV = 39;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1,2'b00,10'h004}, {1'b1,2'b10,10'h3FF}, {1'b0,2'b10,10'h0FF},
    {1'b1,2'b00,10'h005}, {1'b1,2'b10,10'h001}, {1'b1,2'b00,10'h006},
    {1'b1,2'b10,10'h0E0}, {1'b1,2'b00,10'h007}, {1'b1,2'b10,10'h041},
    {1'b1,2'b00,10'h006}, {1'b0,2'b10,10'h0E0}, {1'b1,2'b00,10'h007},
    {1'b0,2'b10,10'h041}, {1'b0,2'b00,10'h007}, {1'b1,2'b00,10'h009},
    {1'b1,2'b10,10'h055}, {1'b0,2'b10,10'h000}, {1'b1,2'b00,10'h010},
    {1'b1,2'b01,10'h123}, {1'b1,2'b01,10'h2AB}, {1'b1,2'b01,10'h3C5},
    {1'b0,2'b00,10'h011}, {1'b1,2'b00,10'h010}, {1'b0,2'b01,10'h123},
    {1'b0,2'b01,10'h2AB}, {1'b0,2'b01,10'h3C5}, {1'b0,2'b00,10'h011},
    {1'b1,2'b00,10'h020}, {1'b1,2'b01,10'h111}, {1'b1,2'b00,10'h020},
    {1'b1,2'b01,10'h0AA}, {1'b1,2'b01,10'h0BB}, {1'b1,2'b01,10'h0CC},
    {1'b1,2'b00,10'h020}, {1'b0,2'b01,10'h0AA}, {1'b0,2'b01,10'h0BB},
    {1'b0,2'b01,10'h0CC}, {1'b1,2'b11,10'h35A}, {1'b0,2'b11,10'h05A}
  };
  // R12 (low byte, zero upper bits), R3 (indexed regs, unmapped), R2 (pointer),
  // R4/R5 (colour group), R6 (step), R7 (phase reset), R8 (mode readback)
  localparam int VREQ [NV] = '{2,2,12, 2,3,2, 3,2,3, 2,3,2, 3,2,2, 3,3,2,
                               4,4,4, 6,2,5, 5,5,6, 7,7,7, 7,7,7, 2,7,7, 7,8,8};

  task automatic chk(input int r, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] s, input logic [9:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = w; sel = s; wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0;
    got_rd = rdata; got_v = rd_valid; got_rs = resync_pulse; got_cal = calib_pulse;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    chk(1, rdata, 10'h000);
    chk(1, {7'd0, rd_valid, resync_pulse, calib_pulse}, 10'h000);
    chk(1, {2'b0, pixel_mask}, 10'h000);
    acc(1'b0, 2'b11, '0); chk(1, got_rd, 10'h000);
    acc(1'b0, 2'b00, '0); chk(1, got_rd, 10'h000);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][12], VEC[i][11:10], VEC[i][9:0]);
      if (!VEC[i][12]) begin
        chk(VREQ[i], got_rd, VEC[i][9:0]);
        chk(12, {9'd0, got_v}, 10'h001);
      end
    end
    // R3: control outputs follow the indexed writes
    chk(3, {2'b0, ctrl2}, 10'h0E0);
    chk(3, {2'b0, ctrl3}, 10'h041);
    // R12: rd_valid drops after the read cycle
    @(negedge clk); chk(12, {9'd0, rd_valid}, 10'h000);

    // R6: wrap from FFh to 00h
    acc(1'b1, 2'b00, 10'h0FF);
    acc(1'b1, 2'b01, 10'h001); acc(1'b1, 2'b01, 10'h002); acc(1'b1, 2'b01, 10'h003);
    acc(1'b0, 2'b00, '0); chk(6, got_rd, 10'h000);
    acc(1'b1, 2'b00, 10'h0FF);
    acc(1'b0, 2'b01, '0); chk(4, got_rd, 10'h001);
    acc(1'b0, 2'b01, '0); chk(5, got_rd, 10'h002);
    acc(1'b0, 2'b01, '0); chk(5, got_rd, 10'h003);

    // R9: 1,0,1 on bit 0 with unrelated accesses between
    acc(1'b1, 2'b11, 10'h001); chk(9, {9'd0, got_rs}, 10'h000);
    acc(1'b1, 2'b00, 10'h004);
    acc(1'b1, 2'b11, 10'h000); chk(9, {9'd0, got_rs}, 10'h000);
    acc(1'b0, 2'b10, '0);
    acc(1'b1, 2'b11, 10'h001); chk(9, {9'd0, got_rs}, 10'h001);
    @(negedge clk); chk(9, {9'd0, resync_pulse}, 10'h000);
    // R9: equal values give no pulse
    acc(1'b1, 2'b11, 10'h001); acc(1'b1, 2'b11, 10'h001);
    acc(1'b1, 2'b11, 10'h001); chk(9, {9'd0, got_rs}, 10'h000);

    // R10: 0,1,0 on bit 5
    acc(1'b1, 2'b11, 10'h000); acc(1'b1, 2'b11, 10'h020);
    chk(10, {9'd0, got_cal}, 10'h000);
    acc(1'b1, 2'b11, 10'h000); chk(10, {9'd0, got_cal}, 10'h001);
    @(negedge clk); chk(10, {9'd0, calib_pulse}, 10'h000);

    // R11: vsync trigger enabled (control 1 bit 0 = 1 from the table)
    chk(11, {2'b0, ctrl1}, 10'h001);
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) chk(11, {9'd0, calib_pulse}, 10'h001);
    @(negedge clk) chk(11, {9'd0, calib_pulse}, 10'h000);
    vsync = 1'b0;
    acc(1'b1, 2'b00, 10'h005); acc(1'b1, 2'b10, 10'h000);
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) chk(11, {9'd0, calib_pulse}, 10'h000);
    @(negedge clk) vsync = 1'b0;

    // R1: reset clears registers again
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    chk(1, {2'b0, ctrl3}, 10'h000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule